// File: doc/BRIEF.md
# Motion Coprocessor System Control and Interrupt Status

This block is the host-side front end of a motion coprocessor. A host drives a 4-bit offset together with separate read and write strobes. Reads and writes that use the same offset reach different registers. Writes to the lower offsets are turned into one-cycle strobes for the conversion, rotation and pulse-width blocks. Reads return the results those blocks present, or the block's own control and status words. Host words are 16 bits wide. The 12 data bits sit in bits 15:4, and bits 3:0 always read as zero.

The control word selects several things: which converter channels run, which completion events may raise the interrupt, the rotation direction, and a divide-by-2 clock mode. In that mode a toggle flop produces a clock enable on every other cycle, so the core can be fed a clock above its rated internal rate. Completion events from the converter and the rotation unit are latched as flags. A summary bit and an active-low interrupt line report that any flag is set. Reading the status word clears the flags.

Top module: `mcp_sysctl`

## Requirements
- R1: While reset is held, and after it is released, the control word reads 0 and the status word reads 0. Also `irq_n` is 1, `tick` is 1, `en_u`/`en_aux`/`fwd_mode` are 0, and no write strobe is active.
- R2: A write at offset 0xD stores host bits 15:4 into the control word. A read at 0xD returns the stored value with bits 3:0 zero. No other access changes the control word.
- R3: The control field outputs follow the stored word: `en_u` is bit 7, `en_aux` is bit 8 and `fwd_mode` is bit 14.
- R4: A write at offset k in 0x0..0xA raises only `wr_stb[k]`, in the same cycle as `bus_wr`, with `wr_val` = host bits 15:4. Writes at 0xB, 0xC, 0xE and 0xF raise no strobe and leave the control word unchanged.
- R5: Reads at 0x0..0x3 return rotation result slot 0..3. Reads at 0x5..0x8 return converter result slot 0..3. Each result is in bits 15:4 with bits 3:0 zero. Offsets 0x4, 0x9..0xC and 0xF read 0. `bus_rdata` is 0 whenever `bus_rd` is low.
- R6: Reading result offsets, in any order and any number of times, does not change the flags or `irq_n`.
- R7: A pulse on `adc_done` while control bit 11 is set sets status bit 4 from the next cycle. With bit 11 clear, the pulse has no effect.
- R8: A pulse on `xf_done` while control bit 10 is set sets status bit 5 from the next cycle. With bit 10 clear, the pulse has no effect.
- R9: Status bit 15 is the OR of bits 4 and 5. `irq_n` is low exactly when bit 15 is set.
- R10: A status read (offset 0xE) returns the current flags and clears them from the next cycle. An enabled event in the same cycle as the read leaves its flag set.
- R11: While control bit 9 is set, `tick` alternates 0/1 on every cycle. The first cycle after the bit is set has `tick` 0. While bit 9 is clear, `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Host write word, data in bits 15:4 |
| bus_rdata | output | 16 | Host read word, data in bits 15:4 |
| wr_stb | output | 11 | One-hot write strobes for offsets 0x0..0xA |
| wr_val | output | DATA_W | Data bits for the strobed register |
| xf_res | input | 4*DATA_W | Rotation results, slot k in bits k*DATA_W up |
| adc_res | input | 4*DATA_W | Converter results, slot k in bits k*DATA_W up |
| adc_done | input | 1 | Converter completion pulse |
| xf_done | input | 1 | Rotation completion pulse |
| en_u | output | 1 | Converter channel U enable |
| en_aux | output | 1 | Auxiliary channel enable |
| fwd_mode | output | 1 | Forward rotation select |
| tick | output | 1 | Internal clock enable |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions check several properties on every cycle. The write strobes are one-hot and only present with `bus_wr`. The control word loads only on a write at 0xD and is otherwise stable. Enabled events always set their flag, and a status read without a new event always clears it. The summary bit read back agrees with `irq_n`. The clock enable alternates in divide mode and stays high otherwise. Some behaviour only the bench scenarios can show: the full offset-to-data map with distinct result values, and the exhaustive readback of all 4096 control values. They also cover the absence of side effects from repeated result reads, and the case of an event that coincides with a status read.

// File: rtl/mcp_pkg.sv
`timescale 1ns/1ps
package mcp_pkg;
  localparam int AW      = 4;
  localparam int HOST_W  = 16;
  localparam int NRES    = 4;
  localparam int N_WSTB  = 11;

  localparam logic [AW-1:0] OFF_XF_LAST = 4'h3;
  localparam logic [AW-1:0] OFF_ADC0    = 4'h5;
  localparam logic [AW-1:0] OFF_ADC_END = 4'h8;
  localparam logic [AW-1:0] OFF_CTL     = 4'hD;
  localparam logic [AW-1:0] OFF_STAT    = 4'hE;

  localparam int BIT_EN_U   = 7;
  localparam int BIT_EN_AUX = 8;
  localparam int BIT_DIV2   = 9;
  localparam int BIT_XF_IE  = 10;
  localparam int BIT_ADC_IE = 11;
  localparam int BIT_FWD    = 14;

  localparam int BIT_ADC_F  = 4;
  localparam int BIT_XF_F   = 5;
  localparam int BIT_SUM    = 15;

  typedef enum logic [2:0] {
    RK_NONE, RK_XF, RK_ADC, RK_CTL, RK_STAT
  } rd_kind_t;

  typedef struct packed {
    logic en_u;
    logic en_aux;
    logic div2;
    logic xf_ie;
    logic adc_ie;
    logic fwd;
  } ctl_t;

  function automatic ctl_t decode_ctl(input logic [HOST_W-1:0] w);
    ctl_t c;
    c.en_u   = w[BIT_EN_U];
    c.en_aux = w[BIT_EN_AUX];
    c.div2   = w[BIT_DIV2];
    c.xf_ie  = w[BIT_XF_IE];
    c.adc_ie = w[BIT_ADC_IE];
    c.fwd    = w[BIT_FWD];
    return c;
  endfunction

  function automatic logic [HOST_W-1:0] status_word(input logic adc_f,
                                                    input logic xf_f);
    logic [HOST_W-1:0] w;
    w = '0;
    w[BIT_ADC_F] = adc_f;
    w[BIT_XF_F]  = xf_f;
    w[BIT_SUM]   = adc_f | xf_f;
    return w;
  endfunction
endpackage

// File: rtl/mcp_decode.sv
`timescale 1ns/1ps
module mcp_decode import mcp_pkg::*; (
  input  logic [AW-1:0]     addr,
  input  logic              rd,
  input  logic              wr,
  output logic [N_WSTB-1:0] wr_stb,
  output logic              ctl_we,
  output logic              stat_re,
  output rd_kind_t          rd_kind,
  output logic [1:0]        rd_idx
);
  logic [AW-1:0] adc_off;

  for (genvar g = 0; g < N_WSTB; g++) begin : g_wstb
    assign wr_stb[g] = wr && (addr == AW'(g));
  end

  assign ctl_we  = wr && (addr == OFF_CTL);
  assign stat_re = rd && (addr == OFF_STAT);
  assign adc_off = addr - OFF_ADC0;

  always_comb begin
    rd_kind = RK_NONE;
    rd_idx  = '0;
    if (addr <= OFF_XF_LAST) begin
      rd_kind = RK_XF;
      rd_idx  = addr[1:0];
    end else if (addr >= OFF_ADC0 && addr <= OFF_ADC_END) begin
      rd_kind = RK_ADC;
      rd_idx  = adc_off[1:0];
    end else if (addr == OFF_CTL) begin
      rd_kind = RK_CTL;
    end else if (addr == OFF_STAT) begin
      rd_kind = RK_STAT;
    end
  end
endmodule

// File: rtl/mcp_ctlreg.sv
`timescale 1ns/1ps
module mcp_ctlreg import mcp_pkg::*; #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctl_q,
  output ctl_t              fields,
  output logic              tick
);
  localparam int PAD_W = HOST_W - DATA_W;

  logic tog;

  assign fields = decode_ctl({ctl_q, {PAD_W{1'b0}}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      tog   <= 1'b0;
    end else begin
      if (we) ctl_q <= wdata;
      tog <= fields.div2 ? ~tog : 1'b0;
    end
  end

  assign tick = fields.div2 ? tog : 1'b1;
endmodule

// File: rtl/mcp_irqstat.sv
`timescale 1ns/1ps
module mcp_irqstat (
  input  logic clk,
  input  logic rst_n,
  input  logic adc_done,
  input  logic xf_done,
  input  logic adc_ie,
  input  logic xf_ie,
  input  logic clr,
  output logic adc_set,
  output logic xf_set,
  output logic adc_f,
  output logic xf_f
);
  assign adc_set = adc_done & adc_ie;
  assign xf_set  = xf_done & xf_ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adc_f <= 1'b0;
      xf_f  <= 1'b0;
    end else begin
      adc_f <= adc_set | (adc_f & ~clr);
      xf_f  <= xf_set | (xf_f & ~clr);
    end
  end
endmodule

// File: rtl/mcp_sysctl.sv
`timescale 1ns/1ps
module mcp_sysctl import mcp_pkg::*; #(
  parameter int DATA_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [AW-1:0]          bus_addr,
  input  logic                   bus_rd,
  input  logic                   bus_wr,
  input  logic [HOST_W-1:0]      bus_wdata,
  output logic [HOST_W-1:0]      bus_rdata,
  output logic [N_WSTB-1:0]      wr_stb,
  output logic [DATA_W-1:0]      wr_val,
  input  logic [NRES*DATA_W-1:0] xf_res,
  input  logic [NRES*DATA_W-1:0] adc_res,
  input  logic                   adc_done,
  input  logic                   xf_done,
  output logic                   en_u,
  output logic                   en_aux,
  output logic                   fwd_mode,
  output logic                   tick,
  output logic                   irq_n
);
  localparam int PAD_W = HOST_W - DATA_W;

  logic              ctl_we;
  logic              stat_clr;
  rd_kind_t          rd_kind;
  logic [1:0]        rd_idx;
  logic [DATA_W-1:0] ctl_q;
  ctl_t              cf;
  logic              div2;
  logic              adc_set;
  logic              xf_set;
  logic              adc_flag;
  logic              xf_flag;
  logic [HOST_W-1:0] stat_w;
  logic [DATA_W-1:0] rd_sel;

  assign wr_val = bus_wdata[HOST_W-1:PAD_W];

  mcp_decode u_dec (
    .addr    (bus_addr),
    .rd      (bus_rd),
    .wr      (bus_wr),
    .wr_stb  (wr_stb),
    .ctl_we  (ctl_we),
    .stat_re (stat_clr),
    .rd_kind (rd_kind),
    .rd_idx  (rd_idx)
  );

  mcp_ctlreg #(.DATA_W(DATA_W)) u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (ctl_we),
    .wdata  (wr_val),
    .ctl_q  (ctl_q),
    .fields (cf),
    .tick   (tick)
  );

  mcp_irqstat u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .adc_done (adc_done),
    .xf_done  (xf_done),
    .adc_ie   (cf.adc_ie),
    .xf_ie    (cf.xf_ie),
    .clr      (stat_clr),
    .adc_set  (adc_set),
    .xf_set   (xf_set),
    .adc_f    (adc_flag),
    .xf_f     (xf_flag)
  );

  assign div2     = cf.div2;
  assign en_u     = cf.en_u;
  assign en_aux   = cf.en_aux;
  assign fwd_mode = cf.fwd;
  assign stat_w   = status_word(adc_flag, xf_flag);
  assign irq_n    = ~stat_w[BIT_SUM];

  always_comb begin
    case (rd_kind)
      RK_XF:   rd_sel = xf_res[int'(rd_idx)*DATA_W +: DATA_W];
      RK_ADC:  rd_sel = adc_res[int'(rd_idx)*DATA_W +: DATA_W];
      RK_CTL:  rd_sel = ctl_q;
      RK_STAT: rd_sel = stat_w[HOST_W-1:PAD_W];
      default: rd_sel = '0;
    endcase
  end

  assign bus_rdata = bus_rd ? {rd_sel, {PAD_W{1'b0}}} : '0;
endmodule

// File: rtl/mcp_sysctl_chk.sv
`timescale 1ns/1ps
module mcp_sysctl_chk import mcp_pkg::*; #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [HOST_W-1:0] bus_wdata,
  input logic [HOST_W-1:0] bus_rdata,
  input logic [N_WSTB-1:0] wr_stb,
  input logic [DATA_W-1:0] ctl_q,
  input logic              adc_set,
  input logic              xf_set,
  input logic              stat_clr,
  input logic              adc_flag,
  input logic              xf_flag,
  input logic              div2,
  input logic              tick,
  input logic              irq_n
);
  localparam int PAD_W = HOST_W - DATA_W;
  localparam logic [HOST_W-1:0] DATA_MASK = {{DATA_W{1'b1}}, {PAD_W{1'b0}}};

  // R4
  wstb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb));

  // R4
  wstb_needs_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb != '0) |-> bus_wr);

  // R2
  ctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_CTL) |=>
      ({ctl_q, {PAD_W{1'b0}}} == ($past(bus_wdata) & DATA_MASK)));

  // R2
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == OFF_CTL) |=> $stable(ctl_q));

  // R5
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == '0));

  // R5
  rd_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[PAD_W-1:0] == '0);

  // R7
  adc_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_set |=> adc_flag);

  // R8
  xf_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xf_set |=> xf_flag);

  // R10
  adc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !adc_set) |=> !adc_flag);

  // R10
  xf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !xf_set) |=> !xf_flag);

  // R9
  irq_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFF_STAT) |-> (bus_rdata[BIT_SUM] == !irq_n));

  // R11
  tick_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div2 && $past(div2)) |-> (tick != $past(tick)));

  // R11
  tick_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !div2 |-> tick);
endmodule

bind mcp_sysctl mcp_sysctl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .wr_stb    (wr_stb),
  .ctl_q     (ctl_q),
  .adc_set   (adc_set),
  .xf_set    (xf_set),
  .stat_clr  (stat_clr),
  .adc_flag  (adc_flag),
  .xf_flag   (xf_flag),
  .div2      (div2),
  .tick      (tick),
  .irq_n     (irq_n)
);

// File: tb/mcp_sysctl_test.sv
`timescale 1ns/1ps
module mcp_sysctl_test;
  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    bus_addr = '0;
  logic          bus_rd = 1'b0;
  logic          bus_wr = 1'b0;
  logic [15:0]   bus_wdata = '0;
  logic [15:0]   bus_rdata;
  logic [10:0]   wr_stb;
  logic [DW-1:0] wr_val;
  logic [4*DW-1:0] xf_res = '0;
  logic [4*DW-1:0] adc_res = '0;
  logic          adc_done = 1'b0;
  logic          xf_done = 1'b0;
  logic          en_u, en_aux, fwd_mode, tick, irq_n;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [10:0]   last_stb;
  logic [DW-1:0] last_val;

  always #4 clk = ~clk;

  mcp_sysctl #(.DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wr_stb(wr_stb), .wr_val(wr_val), .xf_res(xf_res), .adc_res(adc_res),
    .adc_done(adc_done), .xf_done(xf_done), .en_u(en_u), .en_aux(en_aux),
    .fwd_mode(fwd_mode), .tick(tick), .irq_n(irq_n)
  );

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    #2;
    last_stb = wr_stb;
    last_val = wr_val;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #2;
    d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input logic a, input logic x);
    @(negedge clk);
    adc_done = a; xf_done = x;
    @(negedge clk);
    adc_done = 1'b0; xf_done = 1'b0;
  endtask

  function automatic logic [DW-1:0] xf_val(input int k);
    return DW'(12'hA01 + k * 12'h013);
  endfunction

  function automatic logic [DW-1:0] adc_val(input int k);
    return DW'(12'h5C2 + k * 12'h241);
  endfunction

  function automatic logic [15:0] map_exp(input int a, input logic [15:0] ctl_w);
    if (a <= 3) return {xf_val(a), 4'h0};
    if (a >= 5 && a <= 8) return {adc_val(a - 5), 4'h0};
    if (a == 13) return ctl_w;
    return 16'h0000;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    for (int k = 0; k < 4; k++) begin
      xf_res[k*DW +: DW]  = xf_val(k);
      adc_res[k*DW +: DW] = adc_val(k);
    end

    // R1 during reset
    repeat (3) @(negedge clk);
    #2;
    check("R1 irq_n in reset", irq_n, 1);
    check("R1 tick in reset", tick, 1);
    check("R1 fields in reset", {en_u, en_aux, fwd_mode}, 0);
    check("R1 strobes in reset", wr_stb, 0);
    @(negedge clk);
    rst_n = 1'b1;
    rd(4'hD, d); check("R1 ctl after reset", d, 16'h0000);
    rd(4'hE, d); check("R1 status after reset", d, 16'h0000);

    // R2 R3 exhaustive control readback with garbage in low nibble
    for (int v = 0; v < 4096; v++) begin
      logic [15:0] hw;
      hw = 16'(v) << 4;
      wr(4'hD, hw | 16'(v[3:0] ^ 4'h9));
      check("R3 en_u", en_u, hw[7]);
      check("R3 en_aux", en_aux, hw[8]);
      check("R3 fwd_mode", fwd_mode, hw[14]);
      rd(4'hD, d);
      check("R2 ctl readback", d, hw);
    end

    // R4 write strobe sweep over all offsets
    wr(4'hD, 16'h41B0);
    for (int a = 0; a < 16; a++) begin
      logic [15:0] dv;
      if (a == 13) continue;
      dv = 16'(16'h1357 + a * 16'h0F1D);
      wr(4'(a), dv);
      check("R4 strobe", last_stb, (a <= 10) ? (11'd1 << a) : 11'd0);
      if (a <= 10) check("R4 wr_val", last_val, dv[15:4]);
      rd(4'hD, d);
      check("R4 ctl untouched", d, 16'h41B0);
    end

    // R5 read map sweep
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      check("R5 read map", d, map_exp(a, 16'h41B0));
    end
    @(negedge clk); bus_addr = 4'h5; #2;
    check("R5 idle rdata", bus_rdata, 16'h0000);

    // R7 disabled then enabled converter event
    wr(4'hD, 16'h0000);
    pulse(1'b1, 1'b0);
    #2; check("R7 disabled adc no irq", irq_n, 1);
    rd(4'hE, d); check("R7 disabled adc status", d, 16'h0000);
    wr(4'hD, 16'h0800);
    pulse(1'b1, 1'b0);
    #2; check("R9 adc irq low", irq_n, 0);

    // R6 result reads leave flags alone
    for (int r = 0; r < 3; r++) begin
      for (int a = 8; a >= 0; a--) begin
        if (a == 4) continue;
        rd(4'(a), d);
        check("R6 result data stable", d, map_exp(a, 16'h0800));
      end
    end
    #2; check("R6 irq kept", irq_n, 0);
    rd(4'hE, d); check("R7 adc status", d, 16'h8010);
    #2; check("R10 irq released", irq_n, 1);
    rd(4'hE, d); check("R10 cleared", d, 16'h0000);

    // R8 rotation event
    pulse(1'b0, 1'b1);
    rd(4'hE, d); check("R8 xf disabled", d, 16'h0000);
    wr(4'hD, 16'h0400);
    pulse(1'b0, 1'b1);
    #2; check("R9 xf irq low", irq_n, 0);
    rd(4'hE, d); check("R8 xf status", d, 16'h8020);
    wr(4'hD, 16'h0C00);
    pulse(1'b1, 1'b1);
    rd(4'hE, d); check("R9 both flags", d, 16'h8030);

    // R10 event coinciding with status read
    pulse(1'b1, 1'b0);
    @(negedge clk);
    bus_addr = 4'hE; bus_rd = 1'b1; adc_done = 1'b1;
    #2; d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; adc_done = 1'b0;
    check("R10 coincident read", d, 16'h8010);
    rd(4'hE, d); check("R10 flag retained", d, 16'h8010);
    rd(4'hE, d); check("R10 then cleared", d, 16'h0000);

    // R11 clock enable
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #2; check("R11 tick full rate", tick, 1);
    end
    wr(4'hD, 16'h0200);
    begin
      logic prev;
      int ones;
      ones = 0;
      prev = 1'b1;
      for (int i = 0; i < 8; i++) begin
        if (i > 0) @(negedge clk);
        #2;
        if (i == 0) check("R11 first tick low", tick, 0);
        else check("R11 tick alternates", tick, !prev);
        prev = tick;
        if (tick) ones++;
      end
      check("R11 tick count", ones, 4);
    end
    wr(4'hD, 16'h0000);
    @(negedge clk); #2; check("R11 tick restored", tick, 1);

    finished = 1;
    summary();
    $finish;
  end
endmodule